// File: doc/BRIEF.md
# Protection Region Configuration Register File

This block holds the settings of a parameterised set of memory protection regions (sixteen by default). Each region owns an 8-bit configuration byte (read, write and execute permissions, an address matching mode and a lock flag) and one address word. Software reaches the storage through a single register port. A select line chooses between the configuration registers and the address registers. Each configuration register is 32 bits wide and packs the bytes of four consecutive regions. Every stored byte and word is driven out in parallel to the access checker that sits beside this block.

Writes are filtered one byte at a time. A locked region ignores writes to both its byte and its address word until reset. A region whose successor is locked and is in top-of-range mode also keeps its address word, because that word is the lower bound of the locked range. A byte with the reserved permission combination (write allowed, read denied) is dropped. A bypass input suspends all of the lock filtering so that rules can be rewritten or unlocked. A sticky lockdown flag changes how the checker reads the lock bits, so it is exported with the entries.

Top module: `prr_regfile`

## Requirements
- R1: After reset every configuration byte, every address word and the lockdown flag read as zero, so every region is unlocked and its mode is off.
- R2: Byte k (bits 8k+7:8k) of configuration register n holds region 4n+k. Within the byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the mode (00 off, 01 top-of-range, 10 four-byte aligned, 11 power-of-two aligned) and bit 7 is lock. Reading configuration register n returns the four stored bytes in the same positions.
- R3: Bits 6:5 of every configuration byte are reserved. They are discarded on write and always read as zero.
- R4: A byte written with bit 1 set and bit 0 clear leaves that region's byte unchanged, while the other bytes in the same register write still update.
- R5: While a region's lock bit is set and lock_bypass is low, writes to its configuration byte and to its address word are ignored. Unlocked bytes in the same 32-bit write still update.
- R6: While region i+1 is locked with mode 01 (top-of-range) and lock_bypass is low, writes to the address word of region i are ignored.
- R7: While lock_bypass is high, locked regions accept writes, including writes that clear their lock bit, and the top-of-range guard of R6 does not apply.
- R8: With csr_sel low, csr_idx selects an address word. A write stores csr_wdata[ADDR_W-1:0], and a read returns the stored word zero-extended to 32 bits.
- R9: A cycle with lockdown_set high sets lockdown_o from the next cycle, and lockdown_o stays set until reset.
- R10: A configuration register index at or above NUM_ENTRIES/4 changes no region on write and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_sel | input | 1 | 1 selects configuration registers, 0 selects address words |
| csr_idx | input | IDX_W | Register index (IDX_W = clog2(NUM_ENTRIES)) |
| csr_wdata | input | 32 | Write data |
| csr_we | input | 1 | Write enable, acts on the rising clock edge |
| csr_rdata | output | 32 | Combinational read data for the selected register |
| lock_bypass | input | 1 | Suspends lock filtering while high |
| lockdown_set | input | 1 | Sets the sticky lockdown flag |
| lockdown_o | output | 1 | Stored lockdown flag |
| cfg_o | output | NUM_ENTRIES*8 | All configuration bytes, region e at bits 8e+7:8e |
| addr_o | output | NUM_ENTRIES*ADDR_W | All address words, region e at bits ADDR_W*e+ADDR_W-1:ADDR_W*e |

## Verification
The hardest case to reach is the top-of-range guard. Region i+1 must be locked with mode 01 while region i is still writable, and the bench must then target the address word of region i with bypass low. Random byte values seldom produce that pattern and then leave it alone. The directed sequence therefore builds it on purpose, then releases it with the bypass. The random phase keeps the lock bit rare in its data and raises the bypass now and then, so that locked neighbours appear and disappear many times across mixed 32-bit writes.

// File: rtl/prr_pkg.sv
package prr_pkg;

   typedef enum logic [1:0] {
      AM_OFF   = 2'b00,
      AM_TOR   = 2'b01,
      AM_NA4   = 2'b10,
      AM_NAPOT = 2'b11
   } amode_e;

   typedef struct packed {
      logic       lock;
      logic [1:0] rsv;
      amode_e     mode;
      logic       x;
      logic       w;
      logic       r;
   } rcfg_t;

   // Reserved field forced to zero before storage.
   function automatic rcfg_t sanitize(input logic [7:0] raw);
      rcfg_t c;
      c     = rcfg_t'(raw);
      c.rsv = 2'b00;
      return c;
   endfunction

   // Write-without-read is a reserved permission pair.
   function automatic logic perm_reserved(input rcfg_t c);
      return c.w & ~c.r;
   endfunction

endpackage

// File: rtl/prr_cfg_entry.sv
module prr_cfg_entry
   import prr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_byte,
   input  logic       bypass,
   output rcfg_t      cfg_q
);

   rcfg_t cand;
   logic  accept;

   assign cand   = sanitize(wr_byte);
   assign accept = wr_en & (~cfg_q.lock | bypass) & ~perm_reserved(cand);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (accept) cfg_q <= cand;
   end

endmodule

// File: rtl/prr_addr_entry.sv
module prr_addr_entry #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              bypass,
   input  logic              self_lock,
   input  logic              tor_guard,
   output logic [ADDR_W-1:0] addr_q
);

   logic accept;

   assign accept = wr_en & (bypass | ~(self_lock | tor_guard));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (accept) addr_q <= wr_data;
   end

endmodule

// File: rtl/prr_regfile.sv
module prr_regfile
   import prr_pkg::*;
#(
   parameter int  NUM_ENTRIES = 16,
   parameter int  ADDR_W      = 32,
   localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          csr_sel,
   input  logic [IDX_W-1:0]              csr_idx,
   input  logic [31:0]                   csr_wdata,
   input  logic                          csr_we,
   output logic [31:0]                   csr_rdata,
   input  logic                          lock_bypass,
   input  logic                          lockdown_set,
   output logic                          lockdown_o,
   output logic [NUM_ENTRIES*8-1:0]      cfg_o,
   output logic [NUM_ENTRIES*ADDR_W-1:0] addr_o
);

   localparam int NUM_CFG_REGS = NUM_ENTRIES / 4;

   if (NUM_ENTRIES < 4 || NUM_ENTRIES > 64 || (NUM_ENTRIES % 4) != 0) begin : g_bad_entries
      $error("NUM_ENTRIES must be a multiple of 4 in 4..64");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..32");
   end

   rcfg_t             cfg_q    [NUM_ENTRIES];
   logic [ADDR_W-1:0] addr_q   [NUM_ENTRIES];
   logic [31:0]       cfg_word [NUM_CFG_REGS];
   logic              lockdown_q;

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      logic cfg_hit;
      logic addr_hit;
      logic guard;

      assign cfg_hit  = csr_we &  csr_sel & (csr_idx == IDX_W'(e / 4));
      assign addr_hit = csr_we & ~csr_sel & (csr_idx == IDX_W'(e));

      if (e < NUM_ENTRIES - 1) begin : g_guard
         assign guard = cfg_q[e+1].lock & (cfg_q[e+1].mode == AM_TOR);
      end else begin : g_no_guard
         assign guard = 1'b0;
      end

      prr_cfg_entry u_cfg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_hit),
         .wr_byte (csr_wdata[8*(e%4) +: 8]),
         .bypass  (lock_bypass),
         .cfg_q   (cfg_q[e])
      );

      prr_addr_entry #(.ADDR_W(ADDR_W)) u_addr (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (addr_hit),
         .wr_data   (csr_wdata[ADDR_W-1:0]),
         .bypass    (lock_bypass),
         .self_lock (cfg_q[e].lock),
         .tor_guard (guard),
         .addr_q    (addr_q[e])
      );

      assign cfg_o[8*e +: 8]          = cfg_q[e];
      assign addr_o[ADDR_W*e +: ADDR_W] = addr_q[e];
   end

   for (genvar r = 0; r < NUM_CFG_REGS; r++) begin : g_word
      assign cfg_word[r] = {cfg_q[4*r+3], cfg_q[4*r+2], cfg_q[4*r+1], cfg_q[4*r]};
   end

   always_comb begin
      csr_rdata = '0;
      if (csr_sel) begin
         for (int r = 0; r < NUM_CFG_REGS; r++) begin
            if (csr_idx == IDX_W'(r)) csr_rdata = cfg_word[r];
         end
      end else begin
         for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (csr_idx == IDX_W'(e)) csr_rdata = 32'(addr_q[e]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lockdown_q <= 1'b0;
      else        lockdown_q <= lockdown_q | lockdown_set;
   end

   assign lockdown_o = lockdown_q;

endmodule

// File: rtl/prr_regfile_chk.sv
module prr_regfile_chk #(
   parameter int NUM_ENTRIES = 16,
   parameter int ADDR_W      = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          lock_bypass,
   input logic                          lockdown_o,
   input logic [NUM_ENTRIES*8-1:0]      cfg_o,
   input logic [NUM_ENTRIES*ADDR_W-1:0] addr_o
);

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
      // R5
      lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_o[8*e+7] && !lock_bypass) |=>
            ($stable(cfg_o[8*e +: 8]) && $stable(addr_o[ADDR_W*e +: ADDR_W])));

      // R4
      no_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_o[8*e+1] && !cfg_o[8*e]));

      // R3
      rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_o[8*e+6 -: 2] == 2'b00);

      if (e < NUM_ENTRIES - 1) begin : g_tor
         // R6
         tor_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_o[8*(e+1)+7] && cfg_o[8*(e+1)+4 -: 2] == 2'b01 && !lock_bypass) |=>
               $stable(addr_o[ADDR_W*e +: ADDR_W]));
      end
   end

   // R9
   lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lockdown_o |=> lockdown_o);

endmodule

bind prr_regfile prr_regfile_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .ADDR_W      (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lock_bypass (lock_bypass),
   .lockdown_o  (lockdown_o),
   .cfg_o       (cfg_o),
   .addr_o      (addr_o)
);

// File: tb/prr_regfile_test.sv
`timescale 1ns/1ps
module prr_regfile_test;

   localparam int N  = 16;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csr_sel = 1'b0;
   logic [3:0]    csr_idx = '0;
   logic [31:0]   csr_wdata = '0;
   logic          csr_we = 1'b0;
   logic [31:0]   csr_rdata;
   logic          lock_bypass = 1'b0;
   logic          lockdown_set = 1'b0;
   logic          lockdown_o;
   logic [N*8-1:0]  cfg_o;
   logic [N*AW-1:0] addr_o;

   int vectors = 0;
   int fails   = 0;

   logic [7:0]  m_cfg  [N];
   logic [31:0] m_addr [N];
   logic        m_ld;

   always #2.5 clk = ~clk;

   prr_regfile #(.NUM_ENTRIES(N), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_idx(csr_idx),
      .csr_wdata(csr_wdata), .csr_we(csr_we), .csr_rdata(csr_rdata),
      .lock_bypass(lock_bypass), .lockdown_set(lockdown_set),
      .lockdown_o(lockdown_o), .cfg_o(cfg_o), .addr_o(addr_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int e = 0; e < N; e++) begin
         m_cfg[e]  = '0;
         m_addr[e] = '0;
      end
      m_ld = 1'b0;
   endtask

   task automatic model_write(input logic sel, input logic [3:0] idx,
                              input logic [31:0] d, input logic byp);
      logic [7:0] b;
      if (sel) begin
         if (idx < 4'(N/4)) begin
            for (int k = 0; k < 4; k++) begin
               int e;
               e = 4*int'(idx) + k;
               b = d[8*k +: 8] & 8'h9F;
               if (!(m_cfg[e][7] && !byp) && !(b[1] && !b[0])) m_cfg[e] = b;
            end
         end
      end else begin
         int i;
         logic blocked;
         i = int'(idx);
         blocked = m_cfg[i][7];
         if (i < N-1 && m_cfg[i+1][7] && m_cfg[i+1][4:3] == 2'b01) blocked = 1'b1;
         if (!blocked || byp) m_addr[i] = d;
      end
   endtask

   task automatic compare_all(input string tag);
      for (int e = 0; e < N; e++) begin
         chk(tag, 32'(cfg_o[8*e +: 8]), 32'(m_cfg[e]));
         chk(tag, addr_o[AW*e +: AW], m_addr[e]);
      end
      chk(tag, 32'(lockdown_o), 32'(m_ld));
   endtask

   task automatic apply(input logic sel, input logic [3:0] idx, input logic [31:0] d,
                        input logic byp, input logic ld, input string tag);
      @(negedge clk);
      csr_sel = sel; csr_idx = idx; csr_wdata = d; csr_we = 1'b1;
      lock_bypass = byp; lockdown_set = ld;
      @(negedge clk);
      csr_we = 1'b0; lockdown_set = 1'b0;
      model_write(sel, idx, d, byp);
      m_ld = m_ld | ld;
      compare_all(tag);
   endtask

   function automatic logic [31:0] exp_read(input logic sel, input logic [3:0] idx);
      if (sel) begin
         if (idx < 4'(N/4))
            return {m_cfg[4*idx+3], m_cfg[4*idx+2], m_cfg[4*idx+1], m_cfg[4*idx]};
         return 32'h0;
      end
      return m_addr[idx];
   endfunction

   task automatic rd_check(input logic sel, input logic [3:0] idx, input string tag);
      @(negedge clk);
      csr_sel = sel; csr_idx = idx;
      #1;
      chk(tag, csr_rdata, exp_read(sel, idx));
   endtask

   task automatic rd_lit(input logic sel, input logic [3:0] idx,
                         input logic [31:0] lit, input string tag);
      @(negedge clk);
      csr_sel = sel; csr_idx = idx;
      #1;
      chk(tag, csr_rdata, lit);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(5.0 * 200000);
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      model_reset();
      do_reset();

      // R1 reset state
      compare_all("R1 reset");
      rd_lit(1'b1, 4'd0, 32'h0, "R1 cfg read after reset");

      // R2 byte placement and field layout
      apply(1'b1, 4'd0, 32'h0B0D1907, 1'b0, 1'b0, "R2 cfg0 write");
      rd_lit(1'b1, 4'd0, 32'h0B0D1907, "R2 cfg0 readback");
      chk("R2 entry1 mode NAPOT", 32'(cfg_o[12:11]), 32'h3);

      // R3 reserved bits dropped
      apply(1'b1, 4'd1, 32'h45237F61, 1'b0, 1'b0, "R3 cfg1 write");
      rd_lit(1'b1, 4'd1, 32'h05031F01, "R3 reserved bits read zero");

      // R4 write-only permission rejected per byte
      apply(1'b1, 4'd2, 32'h06030201, 1'b0, 1'b0, "R4 cfg2 write");
      rd_lit(1'b1, 4'd2, 32'h00030001, "R4 reserved perm bytes unchanged");

      // R5 lock entry 4, then try to overwrite
      apply(1'b1, 4'd1, 32'h05031F81, 1'b0, 1'b0, "R5 lock entry4");
      apply(1'b1, 4'd1, 32'h11131700, 1'b0, 1'b0, "R5 partial write");
      rd_lit(1'b1, 4'd1, 32'h11131781, "R5 locked byte skipped");
      apply(1'b0, 4'd4, 32'h0000DEAD, 1'b0, 1'b0, "R5 locked addr write");
      rd_lit(1'b0, 4'd4, 32'h0, "R5 locked addr unchanged");

      // R6 entry 9 locked in TOR guards addr8
      apply(1'b1, 4'd2, 32'h00008901, 1'b0, 1'b0, "R6 lock entry9 TOR");
      apply(1'b0, 4'd8, 32'h00001234, 1'b0, 1'b0, "R6 guarded addr8");
      rd_lit(1'b0, 4'd8, 32'h0, "R6 addr8 unchanged");
      apply(1'b0, 4'd10, 32'h00000055, 1'b0, 1'b0, "R8 addr10 write");
      rd_lit(1'b0, 4'd10, 32'h55, "R8 addr10 readback");

      // R7 bypass lifts both filters
      apply(1'b0, 4'd8, 32'h00001234, 1'b1, 1'b0, "R7 bypass addr8");
      rd_lit(1'b0, 4'd8, 32'h1234, "R7 addr8 written under bypass");
      apply(1'b1, 4'd1, 32'h11131700, 1'b1, 1'b0, "R7 clear lock entry4");
      rd_lit(1'b1, 4'd1, 32'h11131700, "R7 lock cleared");
      apply(1'b0, 4'd4, 32'hCAFE0004, 1'b0, 1'b0, "R7 addr4 after unlock");
      rd_lit(1'b0, 4'd4, 32'hCAFE0004, "R7 addr4 readback");

      // R10 out-of-range config index
      apply(1'b1, 4'd7, 32'h07070707, 1'b0, 1'b0, "R10 out-of-range write");
      rd_lit(1'b1, 4'd7, 32'h0, "R10 out-of-range read");

      // R9 sticky lockdown flag
      apply(1'b0, 4'd0, 32'h0, 1'b0, 1'b1, "R9 lockdown set");
      chk("R9 lockdown raised", 32'(lockdown_o), 32'h1);
      apply(1'b0, 4'd1, 32'h0, 1'b0, 1'b0, "R9 lockdown held");
      chk("R9 lockdown sticky", 32'(lockdown_o), 32'h1);

      // Random phase
      for (int n = 0; n < 1500; n++) begin
         logic        sel;
         logic [3:0]  idx;
         logic [31:0] d;
         logic        byp;
         logic        ld;
         sel = 1'($urandom % 2);
         idx = sel ? 4'($urandom % 6) : 4'($urandom % 16);
         d   = $urandom;
         if (sel) begin
            for (int k = 0; k < 4; k++)
               if (($urandom % 6) != 0) d[8*k+7] = 1'b0;
            if (($urandom % 3) == 0) d[4:3] = 2'b01;
         end
         byp = (($urandom % 10) == 0);
         ld  = (($urandom % 300) == 0);
         apply(sel, idx, d, byp, ld, "R5 R6 R7 random");
         if ((n % 50) == 0) begin
            for (int r = 0; r < 5; r++) rd_check(1'b1, 4'(r), "R2 R10 random readback");
            for (int a = 0; a < N; a++) rd_check(1'b0, 4'(a), "R8 random readback");
         end
      end

      // R1 reset after activity
      lock_bypass = 1'b0;
      do_reset();
      compare_all("R1 reset after activity");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule